// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access Protection

This block holds recently used virtual-page to physical-page mappings in a small, fully associative array. Every lookup compares the virtual page number against all entries in parallel. In the same cycle it either returns the physical address or reports a miss. A miss asks the page-table walker for the translation. A matching entry whose permissions do not allow the access raises a protection fault instead of returning an address.

The walker writes translations in through a refill port. If any entry is empty, the refill goes there first. When the array is full, a parameter selects how the victim is chosen: a circular pointer that evicts the oldest entry, or a free-running LFSR that picks an entry at random. A single invalidate-all input empties the array in one cycle, which is what a context switch needs.

Top module: `tlb_assoc`

## Requirements
- R1: After reset every entry is invalid, so a lookup reports a miss and the physical address reads zero.
- R2: A lookup whose virtual page number matches a valid entry, and whose access is permitted, raises the hit output in the same cycle. The physical address is then the entry's physical page number in bits [31:12] with the lookup's untranslated bits [11:0] below it.
- R3: A lookup that matches no valid entry raises the miss output. The hit output stays low and the physical address is zero.
- R4: While lookup-valid is high, exactly one of hit, miss and fault is high. While it is low, all three are low.
- R5: A user-mode access (`lk_user`=1) to an entry refilled with `fill_user_ok`=0 raises the fault output and forces the physical address to zero. The same access in kernel mode hits.
- R6: A write (`lk_write`=1) to an entry refilled with `fill_writable`=0 faults in both modes. A read of that entry hits.
- R7: A refill takes effect at the clock edge. A lookup in the same cycle as the refill sees the old contents, and from the next cycle on the new mapping hits.
- R8: Invalidate-all empties the whole array at one clock edge. A refill presented in the same cycle is discarded.
- R9: A refill always goes into an empty entry while one exists, so no valid mapping is lost before the array is full.
- R10: In FIFO mode, a refill into a full array evicts the entry that was written longest ago.
- R11: In random mode, a refill into a full array replaces exactly one of the existing entries, chosen by a free-running LFSR. All the other entries keep their mappings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| flush_all | input | 1 | Invalidate every entry |
| fill_valid | input | 1 | Refill from the page-table walker |
| fill_vpn | input | VPN_W | Virtual page number being refilled |
| fill_ppn | input | PPN_W | Physical page number for that page |
| fill_user_ok | input | 1 | 1 = user mode may access the page |
| fill_writable | input | 1 | 1 = writes are allowed |
| out_paddr | output | PA_W | Translated address, zero unless hit |
| out_hit | output | 1 | Permitted translation found |
| out_miss | output | 1 | No valid entry matches; walk needed |
| out_fault | output | 1 | Entry found but access denied |

## Verification
Some properties are checked on every cycle by the assertions. When a lookup is valid, the three result flags are mutually exclusive and one of them is always high. No two entries ever match at once. A fault never carries an address, and a hit always passes the page offset through unchanged. Invalidate-all empties the valid bits. A refill into a non-full array always lands in an empty slot, which grows the population by one.

Other behaviour depends on sequences of refills and lookups, so only the bench's scenarios can show it. These cover the same-cycle ordering of a refill against a lookup and the exact eviction order in FIFO mode. They also check that random replacement leaves exactly one old mapping missing, and that a refill is discarded when it coincides with a flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic {
    REPL_FIFO   = 1'b0,
    REPL_RANDOM = 1'b1
  } repl_e;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // Access is denied for user mode on a kernel-only page, or for any write to a read-only page.
  function automatic logic perm_denied(input logic is_user, input logic is_write,
                                       input logic user_ok, input logic writable);
    return (is_user && !user_ok) || (is_write && !writable);
  endfunction

  // Galois-free Fibonacci step, taps 16,14,13,11.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  logic               wr_user_ok,
  input  logic               wr_writable,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] match_vec,
  output logic               any_match,
  output logic [PPN_W-1:0]   sel_ppn,
  output logic               sel_user_ok,
  output logic               sel_writable,
  output logic [ENTRIES-1:0] valid_vec
);

  logic [VPN_W-1:0] tag_q  [ENTRIES];
  logic [PPN_W-1:0] ppn_q  [ENTRIES];
  logic [ENTRIES-1:0] uok_q;
  logic [ENTRIES-1:0] wok_q;
  logic [ENTRIES-1:0] valid_q;

  // Valid bits: flush wins over a refill in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  // Payload storage needs no reset; it is qualified by the valid bits.
  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx] <= wr_vpn;
      ppn_q[wr_idx] <= wr_ppn;
      uok_q[wr_idx] <= wr_user_ok;
      wok_q[wr_idx] <= wr_writable;
    end
  end

  // Parallel tag compare, one comparator per entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (tag_q[g] == lk_vpn);
  end

  assign any_match = |match_vec;
  assign valid_vec = valid_q;

  // OR-based read mux: correct because at most one entry can match.
  always_comb begin
    sel_ppn      = '0;
    sel_user_ok  = 1'b0;
    sel_writable = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        sel_ppn      = sel_ppn | ppn_q[i];
        sel_user_ok  = sel_user_ok | uok_q[i];
        sel_writable = sel_writable | wok_q[i];
      end
    end
  end

  // Tags are unique, so the OR mux never blends two entries.
  p_unique_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  p_fill_grows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && !(&valid_q)) |=>
      ($countones(valid_q) == $past($countones(valid_q)) + 1));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int            ENTRIES = 32,
  parameter tlb_pkg::repl_e REPL   = tlb_pkg::REPL_FIFO,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               fill_en,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               all_valid
);

  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] full_idx;

  assign all_valid = &valid_vec;

  // Lowest-numbered empty entry.
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  if (REPL == tlb_pkg::REPL_FIFO) begin : g_fifo
    logic [IDX_W-1:0] ptr_q;
    // Pointer moves on every accepted refill, so it trails the fill order exactly.
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        ptr_q <= '0;
      end else if (fill_en) begin
        ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
    assign full_idx = ptr_q;
  end else begin : g_rand
    logic [tlb_pkg::LFSR_W-1:0] lfsr_q;
    always_ff @(posedge clk) begin
      if (!rst_n) lfsr_q <= tlb_pkg::LFSR_SEED;
      else        lfsr_q <= tlb_pkg::lfsr_step(lfsr_q);
    end
    assign full_idx = IDX_W'(lfsr_q % tlb_pkg::LFSR_W'(ENTRIES));
  end

  assign victim_idx = all_valid ? full_idx : free_idx;

  p_victim_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !all_valid) |-> !valid_vec[victim_idx]);

  p_victim_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (int'(victim_idx) < ENTRIES));

endmodule

// File: rtl/tlb_check.sv
module tlb_check #(
  parameter int PAGE_BITS = 12,
  parameter int PPN_W     = 20,
  localparam int PA_W     = PPN_W + PAGE_BITS
) (
  input  logic                 lk_valid,
  input  logic                 lk_user,
  input  logic                 lk_write,
  input  logic [PAGE_BITS-1:0] lk_offset,
  input  logic                 any_match,
  input  logic [PPN_W-1:0]     sel_ppn,
  input  logic                 sel_user_ok,
  input  logic                 sel_writable,
  output logic                 hit,
  output logic                 miss,
  output logic                 fault,
  output logic [PA_W-1:0]      paddr
);

  function automatic logic [PA_W-1:0] join_paddr(input logic [PPN_W-1:0] ppn,
                                                 input logic [PAGE_BITS-1:0] off);
    return {ppn, off};
  endfunction

  logic denied;
  assign denied = tlb_pkg::perm_denied(lk_user, lk_write, sel_user_ok, sel_writable);

  assign miss  = lk_valid && !any_match;
  assign fault = lk_valid && any_match && denied;
  assign hit   = lk_valid && any_match && !denied;
  assign paddr = hit ? join_paddr(sel_ppn, lk_offset) : '0;

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int             ENTRIES   = 32,
  parameter int             VA_W      = 32,
  parameter int             PA_W      = 32,
  parameter int             PAGE_BITS = 12,
  parameter tlb_pkg::repl_e REPL      = tlb_pkg::REPL_FIFO,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PPN_W = PA_W - PAGE_BITS,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  input  logic             lk_user,
  input  logic             flush_all,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_user_ok,
  input  logic             fill_writable,
  output logic [PA_W-1:0]  out_paddr,
  output logic             out_hit,
  output logic             out_miss,
  output logic             out_fault
);

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic               any_match;
  logic [PPN_W-1:0]   sel_ppn;
  logic               sel_user_ok;
  logic               sel_writable;
  logic [IDX_W-1:0]   victim_idx;
  logic               all_valid;
  logic               fill_en;

  assign lk_vpn  = lk_vaddr[VA_W-1:PAGE_BITS];
  assign fill_en = fill_valid && !flush_all;

  tlb_victim #(.ENTRIES(ENTRIES), .REPL(REPL)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_all),
    .fill_en    (fill_en),
    .valid_vec  (valid_vec),
    .victim_idx (victim_idx),
    .all_valid  (all_valid)
  );

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush_all),
    .wr_en        (fill_en),
    .wr_idx       (victim_idx),
    .wr_vpn       (fill_vpn),
    .wr_ppn       (fill_ppn),
    .wr_user_ok   (fill_user_ok),
    .wr_writable  (fill_writable),
    .lk_vpn       (lk_vpn),
    .match_vec    (match_vec),
    .any_match    (any_match),
    .sel_ppn      (sel_ppn),
    .sel_user_ok  (sel_user_ok),
    .sel_writable (sel_writable),
    .valid_vec    (valid_vec)
  );

  tlb_check #(.PAGE_BITS(PAGE_BITS), .PPN_W(PPN_W)) u_check (
    .lk_valid     (lk_valid),
    .lk_user      (lk_user),
    .lk_write     (lk_write),
    .lk_offset    (lk_vaddr[PAGE_BITS-1:0]),
    .any_match    (any_match),
    .sel_ppn      (sel_ppn),
    .sel_user_ok  (sel_user_ok),
    .sel_writable (sel_writable),
    .hit          (out_hit),
    .miss         (out_miss),
    .fault        (out_fault),
    .paddr        (out_paddr)
  );

  p_one_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ($countones({out_hit, out_miss, out_fault}) == 1));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(out_hit || out_miss || out_fault));

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> (out_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]));

  p_fault_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fault || out_miss) |-> (out_paddr == '0));

  p_miss_nomatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_miss |-> (match_vec == '0));

endmodule

// File: tb/tlb_assoc_bench.sv
module tlb_assoc_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  logic        rst_n;
  logic        lk_valid, lk_write, lk_user, flush_all;
  logic [31:0] lk_vaddr;
  logic        fill_valid, fill_user_ok, fill_writable;
  logic [19:0] fill_vpn, fill_ppn;
  logic [31:0] out_paddr;
  logic        out_hit, out_miss, out_fault;

  logic        r_lk_valid, r_fill_valid;
  logic [31:0] r_lk_vaddr;
  logic [19:0] r_fill_vpn, r_fill_ppn;
  logic [31:0] r_paddr;
  logic        r_hit, r_miss, r_fault;

  tlb_assoc u_tlb_assoc (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_user(lk_user), .flush_all(flush_all),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_user_ok(fill_user_ok), .fill_writable(fill_writable),
    .out_paddr(out_paddr), .out_hit(out_hit), .out_miss(out_miss), .out_fault(out_fault)
  );

  tlb_assoc #(.ENTRIES(4), .REPL(tlb_pkg::REPL_RANDOM)) u_tlb_assoc_rnd (
    .clk(clk), .rst_n(rst_n), .lk_valid(r_lk_valid), .lk_vaddr(r_lk_vaddr),
    .lk_write(1'b0), .lk_user(1'b0), .flush_all(1'b0),
    .fill_valid(r_fill_valid), .fill_vpn(r_fill_vpn), .fill_ppn(r_fill_ppn),
    .fill_user_ok(1'b1), .fill_writable(1'b1),
    .out_paddr(r_paddr), .out_hit(r_hit), .out_miss(r_miss), .out_fault(r_fault)
  );

  // Expected address, restated from R2.
  function automatic logic [31:0] want_pa(input logic [19:0] ppn, input logic [31:0] va);
    return (ppn << 12) | (va & 32'h0000_0FFF);
  endfunction

  task automatic expect_out(input string req, input logic eh, input logic em,
                            input logic ef, input logic [31:0] ep);
    n_vec++;
    if (out_hit !== eh || out_miss !== em || out_fault !== ef || out_paddr !== ep) begin
      n_bad++;
      $display("FAIL %s: got hit=%b miss=%b fault=%b pa=%h, expected hit=%b miss=%b fault=%b pa=%h",
               req, out_hit, out_miss, out_fault, out_paddr, eh, em, ef, ep);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic wr, input logic usr);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_user = usr;
    #1;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic uok, input logic wok);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    fill_user_ok = uok; fill_writable = wok;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic t_reset_r1;
    look(32'h1234_5678, 1'b0, 1'b0);
    expect_out("R1 reset miss", 1'b0, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic t_idle_r4;
    @(negedge clk);
    lk_valid = 1'b0; lk_vaddr = 32'h0001_2000;
    #1;
    expect_out("R4 idle quiet", 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_hit_r2;
    fill(20'h00012, 20'h0ABCD, 1'b1, 1'b1);
    look(32'h0001_2345, 1'b0, 1'b1);
    expect_out("R2 hit user read", 1'b1, 1'b0, 1'b0, want_pa(20'h0ABCD, 32'h0001_2345));
    look(32'h0001_2FFF, 1'b1, 1'b0);
    expect_out("R2 hit kernel write", 1'b1, 1'b0, 1'b0, want_pa(20'h0ABCD, 32'h0001_2FFF));
  endtask

  task automatic t_miss_r3;
    look(32'h0001_3345, 1'b0, 1'b0);
    expect_out("R3 miss neighbour page", 1'b0, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic t_same_cycle_r7;
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'h00777; fill_ppn = 20'h07070;
    fill_user_ok = 1'b1; fill_writable = 1'b1;
    lk_valid = 1'b1; lk_vaddr = 32'h0077_7010; lk_write = 1'b0; lk_user = 1'b0;
    #1;
    expect_out("R7 same cycle sees old", 1'b0, 1'b1, 1'b0, 32'h0);
    @(negedge clk);
    fill_valid = 1'b0;
    #1;
    expect_out("R7 next cycle hits", 1'b1, 1'b0, 1'b0, want_pa(20'h07070, 32'h0077_7010));
  endtask

  task automatic t_perm_r5_r6;
    fill(20'h00100, 20'h11111, 1'b0, 1'b1);
    look(32'h0010_0044, 1'b0, 1'b1);
    expect_out("R5 user on kernel page", 1'b0, 1'b0, 1'b1, 32'h0);
    look(32'h0010_0044, 1'b0, 1'b0);
    expect_out("R5 kernel on kernel page", 1'b1, 1'b0, 1'b0, want_pa(20'h11111, 32'h0010_0044));
    fill(20'h00200, 20'h22222, 1'b1, 1'b0);
    look(32'h0020_0abc, 1'b1, 1'b1);
    expect_out("R6 user write read-only", 1'b0, 1'b0, 1'b1, 32'h0);
    look(32'h0020_0abc, 1'b1, 1'b0);
    expect_out("R6 kernel write read-only", 1'b0, 1'b0, 1'b1, 32'h0);
    look(32'h0020_0abc, 1'b0, 1'b1);
    expect_out("R6 user read read-only", 1'b1, 1'b0, 1'b0, want_pa(20'h22222, 32'h0020_0abc));
  endtask

  task automatic t_flush_r8;
    @(negedge clk);
    flush_all = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h00300; fill_ppn = 20'h33333;
    fill_user_ok = 1'b1; fill_writable = 1'b1;
    @(negedge clk);
    flush_all = 1'b0; fill_valid = 1'b0;
    look(32'h0001_2345, 1'b0, 1'b0);
    expect_out("R8 old mapping flushed", 1'b0, 1'b1, 1'b0, 32'h0);
    look(32'h0030_0000, 1'b0, 1'b0);
    expect_out("R8 coincident fill dropped", 1'b0, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic t_fifo_r9_r10;
    int lost = 0;
    for (int i = 0; i < 32; i++) fill(20'h01000 + 20'(i), 20'h05000 + 20'(i), 1'b1, 1'b1);
    for (int i = 0; i < 32; i++) begin
      look(32'h0100_0000 + (i << 12) + 32'h10, 1'b0, 1'b0);
      if (!out_hit || out_paddr !== want_pa(20'h05000 + 20'(i), 32'h10)) lost++;
    end
    n_vec++;
    if (lost != 0) begin
      n_bad++;
      $display("FAIL R9 fill of empty array: %0d mappings lost, expected 0", lost);
    end
    fill(20'h02000, 20'h06000, 1'b1, 1'b1);
    look(32'h0100_0000, 1'b0, 1'b0);
    expect_out("R10 oldest evicted", 1'b0, 1'b1, 1'b0, 32'h0);
    look(32'h0100_1000, 1'b0, 1'b0);
    expect_out("R10 second oldest kept", 1'b1, 1'b0, 1'b0, want_pa(20'h05001, 32'h0));
    look(32'h0200_0008, 1'b0, 1'b0);
    expect_out("R10 new entry hits", 1'b1, 1'b0, 1'b0, want_pa(20'h06000, 32'h8));
    fill(20'h02001, 20'h06001, 1'b1, 1'b1);
    look(32'h0100_1000, 1'b0, 1'b0);
    expect_out("R10 next oldest evicted", 1'b0, 1'b1, 1'b0, 32'h0);
    look(32'h0101_F000, 1'b0, 1'b0);
    expect_out("R10 youngest original kept", 1'b1, 1'b0, 1'b0, want_pa(20'h0501F, 32'h0));
  endtask

  task automatic r_fill(input logic [19:0] vpn, input logic [19:0] ppn);
    @(negedge clk);
    r_fill_valid = 1'b1; r_fill_vpn = vpn; r_fill_ppn = ppn;
    @(negedge clk);
    r_fill_valid = 1'b0;
  endtask

  task automatic t_random_r11;
    int kept = 0;
    for (int i = 0; i < 4; i++) r_fill(20'h00040 + 20'(i), 20'h00400 + 20'(i));
    r_fill(20'h00099, 20'h00999);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      r_lk_valid = 1'b1; r_lk_vaddr = 32'h0004_0000 + (i << 12);
      #1;
      if (r_hit && r_paddr == want_pa(20'h00400 + 20'(i), 32'h0)) kept++;
    end
    n_vec++;
    if (kept != 3) begin
      n_bad++;
      $display("FAIL R11 random eviction: %0d old mappings kept, expected 3", kept);
    end
    @(negedge clk);
    r_lk_vaddr = 32'h0009_9123;
    #1;
    n_vec++;
    if (!r_hit || r_paddr !== 32'h0099_9123) begin
      n_bad++;
      $display("FAIL R11 new entry: hit=%b pa=%h, expected hit=1 pa=00999123", r_hit, r_paddr);
    end
    r_lk_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lk_valid = 1'b0; lk_vaddr = '0; lk_write = 1'b0; lk_user = 1'b0;
    flush_all = 1'b0; fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0;
    fill_user_ok = 1'b0; fill_writable = 1'b0;
    r_lk_valid = 1'b0; r_lk_vaddr = '0; r_fill_valid = 1'b0; r_fill_vpn = '0; r_fill_ppn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_idle_r4();
    t_hit_r2();
    t_miss_r3();
    t_same_cycle_r7();
    t_perm_r5_r6();
    t_flush_r8();
    t_fifo_r9_r10();
    t_random_r11();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule